// File: doc/BRIEF.md
# Prescaled 64-bit Machine Timer

This block keeps a 64-bit time count for one processor and raises a timer interrupt when that count reaches a programmed 64-bit compare value. A tick divider cuts the system clock down to a slower tick rate. On every tick the count grows by a programmable step, so software can choose a tick period and an increment that together give a fixed time unit. For example, a divider setting of 47 at 48 MHz gives a 1 us tick, and so does 199 at 200 MHz.

Software reaches every register through a 32-bit request/response stream port, so each 64-bit value is split into a low word and a high word. Half reads return live values and nothing is snapshotted. Software must therefore guard against the count moving between the two reads. It updates the compare value in three writes: the low word to all ones, then the high word, then the low word. Divider and step are only meant to change while counting is switched off.

The request channel follows valid/ready rules: a request moves when `req_valid_i` and `req_ready_o` are both high. Every accepted request produces exactly one response, in order, on the valid/ready response channel. At most one response is held at a time. `req_ready_o` is high when no response is held, or when the held response is being taken in the same cycle. A held response keeps its data unchanged until it is taken.

Top module: `tick_timer64`

## Requirements
- R1: After reset the time count is 0, the compare value is all ones, the control word (byte offset 0x00) reads 0, the configuration word (0x04) reads 0x0001_0000 (divider 0, step 1), interrupt enable (0x18) reads 0 and `irq_o` is low.
- R2: While the active bit (bit 0 of 0x00) is set, a tick occurs once every (divider + 1) clock cycles, and each tick adds the step to the time count. The divider is bits 11:0 and the step is bits 23:16 of 0x04.
- R3: While the active bit is clear, the time count holds its value and the tick divider restarts from zero. After re-activation the first tick therefore comes a full (divider + 1) cycles later.
- R4: Time low/high sit at 0x08/0x0C and compare low/high at 0x10/0x14. Each half can be written alone and read back live, with no latching of the other half. Unmapped offsets read 0.
- R5: Bit 0 of the status word (0x1C) is 1 exactly when the time count is greater than or equal to the compare value, unsigned. `irq_o` is high when that bit and bit 0 of the enable word (0x18) are both 1.
- R6: The time count wraps from all ones through zero and keeps counting. With a compare value near all ones, the status bit goes from 1 back to 0 after the wrap.
- R7: Writing all ones to the compare low word never makes the compare value smaller. The three-write update (low to all ones, high, low) leaves the status bit at 0 throughout when the count stays below both the old and the new compare value.
- R8: Writing 1 to bit 0 of the test word (0x20) drives `irq_o` high for exactly one cycle, the cycle after the write is accepted, whatever the enable.
- R9: Each accepted request yields one response in order. A write response carries data 0. While `rsp_ready_i` is low a held response keeps its valid and data unchanged, and `req_ready_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low reset |
| req_valid_i | input | 1 | Request valid |
| req_ready_o | output | 1 | Request ready |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 6 | Byte offset of register |
| req_wdata_i | input | 32 | Write data |
| rsp_valid_o | output | 1 | Response valid |
| rsp_ready_i | input | 1 | Response ready |
| rsp_rdata_o | output | 32 | Read data (0 for writes) |
| irq_o | output | 1 | Timer interrupt |

## Verification
Some properties are checked on every cycle:
- the count grows by exactly the step on each tick;
- the count holds while counting is off;
- a stalled response stays frozen;
- an accepted request always yields a response;
- an enabled expiry always drives the interrupt.

Other behaviour needs the bench's scenarios:
- the tick spacing of divider + 1 cycles and the divider restart after re-activation, found by comparing time reads against cycle counts;
- the wrap past all ones and the status falling after it;
- the three-write compare update staying quiet;
- the one-cycle test pulse;
- the reset values.

// File: rtl/tmr64_pkg.sv
package tmr64_pkg;
  localparam int unsigned DATA_W = 32;

  typedef enum logic [3:0] {
    IDX_CTRL = 4'd0,
    IDX_CFG  = 4'd1,
    IDX_TLO  = 4'd2,
    IDX_THI  = 4'd3,
    IDX_CLO  = 4'd4,
    IDX_CHI  = 4'd5,
    IDX_IEN  = 4'd6,
    IDX_IST  = 4'd7,
    IDX_ITST = 4'd8
  } reg_idx_e;

  localparam int unsigned LAST_IDX = 8;
endpackage

// File: rtl/tmr64_port.sv
module tmr64_port
  import tmr64_pkg::*;
#(
  parameter int unsigned AW = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic              acc_o,
  output logic              acc_we_o,
  output logic              acc_hit_o,
  output reg_idx_e          acc_idx_o,
  output logic [DATA_W-1:0] acc_wdata_o
);
  localparam int unsigned WIDX_W = AW - 2;

  logic [WIDX_W-1:0] widx;
  logic              unused_lsb;

  assign widx       = req_addr_i[AW-1:2];
  assign unused_lsb = ^req_addr_i[1:0];

  assign req_ready_o = !rsp_valid_o || rsp_ready_i;
  assign acc_o       = req_valid_i && req_ready_o;
  assign acc_we_o    = req_write_i;
  assign acc_hit_o   = (widx <= WIDX_W'(LAST_IDX));
  assign acc_idx_o   = reg_idx_e'(widx[3:0]);
  assign acc_wdata_o = req_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else if (acc_o) begin
      rsp_valid_o <= 1'b1;
      rsp_rdata_o <= req_write_i ? '0 : rd_data_i;
    end else if (rsp_ready_i) begin
      rsp_valid_o <= 1'b0;
    end
  end

  // R9
  rsp_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_ready_i) |=> (rsp_valid_o && $stable(rsp_rdata_o)));

  // R9
  rsp_follows_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_o |=> rsp_valid_o);
endmodule

// File: rtl/tmr64_regs.sv
module tmr64_regs
  import tmr64_pkg::*;
#(
  parameter int unsigned TIME_W  = 64,
  parameter int unsigned PRESC_W = 12,
  parameter int unsigned STEP_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               wr_i,
  input  logic               hit_i,
  input  reg_idx_e           idx_i,
  input  logic [DATA_W-1:0]  wdata_i,
  input  logic [TIME_W-1:0]  time_i,
  input  logic               expired_i,
  output logic               active_o,
  output logic [PRESC_W-1:0] presc_o,
  output logic [STEP_W-1:0]  step_o,
  output logic [TIME_W-1:0]  cmp_o,
  output logic               ien_o,
  output logic               test_pulse_o,
  output logic               time_wr_lo_o,
  output logic               time_wr_hi_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int unsigned HALF     = TIME_W / 2;
  localparam int unsigned STEP_LSB = 16;

  logic wr_ctrl, wr_cfg, wr_clo, wr_chi, wr_ien, wr_itst;

  always_comb begin
    wr_ctrl      = 1'b0;
    wr_cfg       = 1'b0;
    wr_clo       = 1'b0;
    wr_chi       = 1'b0;
    wr_ien       = 1'b0;
    wr_itst      = 1'b0;
    time_wr_lo_o = 1'b0;
    time_wr_hi_o = 1'b0;
    if (wr_i && hit_i) begin
      case (idx_i)
        IDX_CTRL: wr_ctrl      = 1'b1;
        IDX_CFG:  wr_cfg       = 1'b1;
        IDX_TLO:  time_wr_lo_o = 1'b1;
        IDX_THI:  time_wr_hi_o = 1'b1;
        IDX_CLO:  wr_clo       = 1'b1;
        IDX_CHI:  wr_chi       = 1'b1;
        IDX_IEN:  wr_ien       = 1'b1;
        IDX_ITST: wr_itst      = 1'b1;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_o     <= 1'b0;
      presc_o      <= '0;
      step_o       <= STEP_W'(1);
      cmp_o        <= '1;
      ien_o        <= 1'b0;
      test_pulse_o <= 1'b0;
    end else begin
      test_pulse_o <= wr_itst && wdata_i[0];
      if (wr_ctrl) active_o <= wdata_i[0];
      if (wr_cfg) begin
        presc_o <= wdata_i[PRESC_W-1:0];
        step_o  <= wdata_i[STEP_LSB +: STEP_W];
      end
      if (wr_clo) cmp_o[HALF-1:0]      <= wdata_i;
      if (wr_chi) cmp_o[TIME_W-1:HALF] <= wdata_i;
      if (wr_ien) ien_o <= wdata_i[0];
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (hit_i) begin
      case (idx_i)
        IDX_CTRL: rd_data_o[0] = active_o;
        IDX_CFG: begin
          rd_data_o[PRESC_W-1:0]          = presc_o;
          rd_data_o[STEP_LSB +: STEP_W]   = step_o;
        end
        IDX_TLO:  rd_data_o = time_i[HALF-1:0];
        IDX_THI:  rd_data_o = time_i[TIME_W-1:HALF];
        IDX_CLO:  rd_data_o = cmp_o[HALF-1:0];
        IDX_CHI:  rd_data_o = cmp_o[TIME_W-1:HALF];
        IDX_IEN:  rd_data_o[0] = ien_o;
        IDX_IST:  rd_data_o[0] = expired_i;
        default:  rd_data_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/tmr64_prescale.sv
module tmr64_prescale #(
  parameter int unsigned PRESC_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               active_i,
  input  logic [PRESC_W-1:0] presc_i,
  output logic               tick_o
);
  logic [PRESC_W-1:0] cnt_q;

  assign tick_o = active_i && (cnt_q >= presc_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       cnt_q <= '0;
    else if (!active_i) cnt_q <= '0;
    else if (tick_o)   cnt_q <= '0;
    else               cnt_q <= cnt_q + PRESC_W'(1);
  end
endmodule

// File: rtl/tmr64_counter.sv
module tmr64_counter #(
  parameter int unsigned TIME_W = 64,
  parameter int unsigned STEP_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              active_i,
  input  logic              tick_i,
  input  logic [STEP_W-1:0] step_i,
  input  logic              wr_lo_i,
  input  logic              wr_hi_i,
  input  logic [TIME_W/2-1:0] wdata_i,
  output logic [TIME_W-1:0] time_o
);
  localparam int unsigned HALF = TIME_W / 2;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      time_o <= '0;
    end else if (wr_lo_i || wr_hi_i) begin
      if (wr_lo_i) time_o[HALF-1:0]      <= wdata_i;
      if (wr_hi_i) time_o[TIME_W-1:HALF] <= wdata_i;
    end else if (tick_i) begin
      time_o <= time_o + TIME_W'(step_i);
    end
  end

  // R2
  step_advance_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_i && !wr_lo_i && !wr_hi_i) |=> (time_o == $past(time_o) + TIME_W'($past(step_i))));

  // R3
  idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && !wr_lo_i && !wr_hi_i) |=> $stable(time_o));
endmodule

// File: rtl/tick_timer64.sv
module tick_timer64
  import tmr64_pkg::*;
#(
  parameter int unsigned AW      = 6,
  parameter int unsigned TIME_W  = 64,
  parameter int unsigned PRESC_W = 12,
  parameter int unsigned STEP_W  = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic              req_write_i,
  input  logic [AW-1:0]     req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              rsp_valid_o,
  input  logic              rsp_ready_i,
  output logic [DATA_W-1:0] rsp_rdata_o,
  output logic              irq_o
);
  logic              acc, acc_we, acc_hit;
  reg_idx_e          acc_idx;
  logic [DATA_W-1:0] acc_wdata, rd_data;
  logic              active, ien, test_pulse, tick, expired;
  logic              time_wr_lo, time_wr_hi;
  logic [PRESC_W-1:0] presc;
  logic [STEP_W-1:0]  step;
  logic [TIME_W-1:0]  time_val, cmp_val;

  tmr64_port #(.AW(AW)) u_port (
    .clk_i, .rst_ni,
    .req_valid_i, .req_ready_o, .req_write_i, .req_addr_i, .req_wdata_i,
    .rsp_valid_o, .rsp_ready_i, .rsp_rdata_o,
    .rd_data_i   (rd_data),
    .acc_o       (acc),
    .acc_we_o    (acc_we),
    .acc_hit_o   (acc_hit),
    .acc_idx_o   (acc_idx),
    .acc_wdata_o (acc_wdata)
  );

  tmr64_regs #(.TIME_W(TIME_W), .PRESC_W(PRESC_W), .STEP_W(STEP_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i         (acc && acc_we),
    .hit_i        (acc_hit),
    .idx_i        (acc_idx),
    .wdata_i      (acc_wdata),
    .time_i       (time_val),
    .expired_i    (expired),
    .active_o     (active),
    .presc_o      (presc),
    .step_o       (step),
    .cmp_o        (cmp_val),
    .ien_o        (ien),
    .test_pulse_o (test_pulse),
    .time_wr_lo_o (time_wr_lo),
    .time_wr_hi_o (time_wr_hi),
    .rd_data_o    (rd_data)
  );

  tmr64_prescale #(.PRESC_W(PRESC_W)) u_presc (
    .clk_i, .rst_ni,
    .active_i (active),
    .presc_i  (presc),
    .tick_o   (tick)
  );

  tmr64_counter #(.TIME_W(TIME_W), .STEP_W(STEP_W)) u_count (
    .clk_i, .rst_ni,
    .active_i (active),
    .tick_i   (tick),
    .step_i   (step),
    .wr_lo_i  (time_wr_lo),
    .wr_hi_i  (time_wr_hi),
    .wdata_i  (acc_wdata),
    .time_o   (time_val)
  );

  assign expired = (time_val >= cmp_val);
  assign irq_o   = (expired && ien) || test_pulse;

  // R5
  enabled_expiry_irq_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ien && (time_val >= cmp_val)) |-> irq_o);
endmodule

// File: tb/tick_timer64_bench.sv
module tick_timer64_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, rsp_ready = 1'b1;
  logic [5:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready, rsp_valid, irq;
  logic [31:0] rsp_rdata;

  int checks = 0, fails = 0, cyc = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer64 u_tick_timer64 (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_write_i(req_write),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_ready_i(rsp_ready), .rsp_rdata_o(rsp_rdata),
    .irq_o(irq)
  );

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  // monitor: pops one expected item per delivered response
  always begin
    @(negedge clk); #1;
    if (rst_n && rsp_valid && rsp_ready) begin
      if (exp_q.size() == 0) chk(1'b0, "R9 unexpected response", 64'(rsp_rdata), 64'h0);
      else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk(rsp_rdata == e, t, 64'(rsp_rdata), 64'(e));
      end
    end
  end

  task automatic do_req(input bit we, input logic [5:0] a, input logic [31:0] d,
                        input logic [31:0] expv, input string tag, output int mark);
    @(negedge clk);
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d;
    exp_q.push_back(we ? 32'h0 : expv);
    tag_q.push_back(tag);
    #1;
    while (!req_ready) begin @(negedge clk); #1; end
    mark = cyc;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic wr(input logic [5:0] a, input logic [31:0] d);
    int m;
    do_req(1'b1, a, d, 32'h0, "R9 write response", m);
  endtask

  task automatic rd(input logic [5:0] a, input logic [31:0] expv, input string tag);
    int m;
    do_req(1'b0, a, 32'h0, expv, tag, m);
  endtask

  task automatic wait_drain();
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  task automatic sample_irq(input logic e, input string tag);
    @(negedge clk); #1;
    chk(irq == e, tag, 64'(irq), 64'(e));
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    chk(1'b0, "watchdog expired", 64'h0, 64'h1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [63:0] t_exp, c_val;
    int ma, md, ticks;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    #1 chk(irq == 1'b0, "R1 irq after reset", 64'(irq), 64'h0);
    rd(6'h00, 32'h0, "R1 control reset");
    rd(6'h04, 32'h0001_0000, "R1 config reset");
    rd(6'h08, 32'h0, "R1 time low reset");
    rd(6'h0C, 32'h0, "R1 time high reset");
    rd(6'h10, 32'hFFFF_FFFF, "R1 compare low reset");
    rd(6'h14, 32'hFFFF_FFFF, "R1 compare high reset");
    rd(6'h18, 32'h0, "R1 enable reset");
    rd(6'h1C, 32'h0, "R1 status reset");

    // R4 half access and unmapped
    wr(6'h08, 32'h1234_5678);
    wr(6'h0C, 32'h0000_0001);
    rd(6'h08, 32'h1234_5678, "R4 time low readback");
    rd(6'h0C, 32'h0000_0001, "R4 time high readback");
    wr(6'h10, 32'h0000_0010);
    wr(6'h14, 32'h0000_0000);
    rd(6'h10, 32'h0000_0010, "R4 compare low readback");
    rd(6'h14, 32'h0, "R4 compare high readback");
    rd(6'h24, 32'h0, "R4 unmapped reads zero");
    rd(6'h3C, 32'h0, "R4 unmapped top reads zero");

    // R5 status and enable: time 1_12345678 >= compare 0_00000010
    rd(6'h1C, 32'h1, "R5 status set when time above compare");
    wait_drain();
    sample_irq(1'b0, "R5 irq low while disabled");
    wr(6'h18, 32'h1);
    sample_irq(1'b1, "R5 irq high when enabled and expired");
    wr(6'h14, 32'h0000_0001);
    wr(6'h10, 32'h1234_5678);
    rd(6'h1C, 32'h1, "R5 status set at equality");
    wr(6'h10, 32'h1234_5679);
    rd(6'h1C, 32'h0, "R5 status clear one below compare");
    wait_drain();
    sample_irq(1'b0, "R5 irq low when not expired");
    wr(6'h18, 32'h0);

    // R7 three-write compare update: time 1_12345678, old 2_00000005, new 3_00000000
    wr(6'h14, 32'h2);
    wr(6'h10, 32'h5);
    rd(6'h1C, 32'h0, "R7 status clear before update");
    wr(6'h10, 32'hFFFF_FFFF);
    rd(6'h1C, 32'h0, "R7 status clear after low all ones");
    wr(6'h14, 32'h3);
    rd(6'h1C, 32'h0, "R7 status clear after high write");
    wr(6'h10, 32'h0);
    rd(6'h1C, 32'h0, "R7 status clear after final low");
    rd(6'h14, 32'h3, "R7 compare high updated");

    // R8 test pulse
    wr(6'h20, 32'h1);
    #1 chk(irq == 1'b1, "R8 test pulse high", 64'(irq), 64'h1);
    sample_irq(1'b0, "R8 test pulse one cycle only");

    // R2/R3 counting with divider 3, step 5
    wr(6'h08, 32'h0);
    wr(6'h0C, 32'h0);
    wr(6'h04, 32'h0005_0003);
    rd(6'h04, 32'h0005_0003, "R2 config readback");
    do_req(1'b1, 6'h00, 32'h1, 32'h0, "R9 write response", ma);
    repeat (13) @(negedge clk);
    do_req(1'b1, 6'h00, 32'h0, 32'h0, "R9 write response", md);
    ticks = (md - ma) / 4;
    t_exp = 64'(ticks) * 64'd5;
    rd(6'h08, t_exp[31:0], "R2 time after first active window");
    repeat (5) @(negedge clk);
    rd(6'h08, t_exp[31:0], "R3 time held while inactive");
    rd(6'h0C, t_exp[63:32], "R3 time high held");
    // second window: divider restarts from zero
    do_req(1'b1, 6'h00, 32'h1, 32'h0, "R9 write response", ma);
    repeat (6) @(negedge clk);
    do_req(1'b1, 6'h00, 32'h0, 32'h0, "R9 write response", md);
    t_exp = t_exp + 64'((md - ma) / 4) * 64'd5;
    rd(6'h08, t_exp[31:0], "R3 divider restart after reactivation");

    // R6 wrap: time FFFF_FFFF_FFFF_FFFE, divider 0, step 3, compare near all ones
    wr(6'h04, 32'h0003_0000);
    wr(6'h08, 32'hFFFF_FFFE);
    wr(6'h0C, 32'hFFFF_FFFF);
    c_val = 64'hFFFF_FFFF_FFFF_FFF0;
    wr(6'h10, c_val[31:0]);
    wr(6'h14, c_val[63:32]);
    rd(6'h1C, 32'h1, "R6 status set before wrap");
    do_req(1'b1, 6'h00, 32'h1, 32'h0, "R9 write response", ma);
    do_req(1'b1, 6'h00, 32'h0, 32'h0, "R9 write response", md);
    t_exp = 64'hFFFF_FFFF_FFFF_FFFE + 64'(md - ma) * 64'd3;
    rd(6'h08, t_exp[31:0], "R6 time low after wrap");
    rd(6'h0C, t_exp[63:32], "R6 time high after wrap");
    rd(6'h1C, {31'h0, t_exp >= c_val}, "R6 status after wrap");

    // R9 back-pressure
    wait_drain();
    @(negedge clk);
    rsp_ready = 1'b0;
    rd(6'h0C, t_exp[63:32], "R9 stalled read data");
    #1 chk(rsp_valid == 1'b1, "R9 response held", 64'(rsp_valid), 64'h1);
    chk(req_ready == 1'b0, "R9 request not ready while stalled", 64'(req_ready), 64'h0);
    begin
      logic [31:0] held;
      held = rsp_rdata;
      repeat (3) @(negedge clk);
      #1 chk(rsp_valid && rsp_rdata == held, "R9 response stable while stalled", 64'(rsp_rdata), 64'(held));
    end
    @(negedge clk);
    rsp_ready = 1'b1;
    wait_drain();
    repeat (2) @(negedge clk);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule